// File: doc/BRIEF.md
# Loop-Disconnect Pulse Dialer

This block turns a stream of queued dialing symbols into timed loop breaks on a dial-pulse line. The line is high while the loop is made and low while it is broken. Each decimal digit becomes a train of break/make pulses followed by a long make gap. The pulse rate (10 or 20 pulses per second) and the make/break ratio (40:60 or 33:67) are selectable. The block also produces hook-flash breaks in four lengths, each followed by a recovery interval. It inserts long waits for stored pause symbols, handles a pulse-to-tone switch symbol and, when lock is enabled, holds the line broken for a delay after off-hook.

Symbols arrive over a valid/ready handshake. Each symbol or flash that completes gives a one-cycle done strobe. A mute flag is high whenever a timed sequence is running. All durations are counted in millisecond ticks, which a prescaler derives from the clock.

Top module: `loop_pulse_dialer`

## Requirements
- R1: While off_hook_i is low, and after reset, dp_o is 1, mute_o is 0, done_o is 0 and sym_ready_o is 0. After off-hook with lock disabled, sym_ready_o becomes 1 when idle.
- R2: A pulse-mode digit code n (1..9) produces exactly n break pulses, and code 0 produces 10.
- R3: At 10 pps (rate20_i=0), mode_i=2'b01 gives a 60 ms break and a 40 ms make per pulse. mode_i=2'b10 or 2'b11 gives a 67 ms break and a 33 ms make.
- R4: At 20 pps (rate20_i=1), the break/make lengths are 30/20 ms for mode_i=2'b01 and 33/17 ms for mode_i=2'b1x.
- R5: After the make of a digit's last pulse, the line stays made for a further 800 ms, and then done_o pulses for one cycle.
- R6: A flash request breaks the line for 600, 300, 73 or 100 ms for flash_sel_i = 0, 1, 2, 3. A 1000 ms make follows, then done_o. This happens in tone and pulse mode alike.
- R7: When a flash request and a valid symbol arrive in the same idle cycle, the flash is served first. The symbol stays pending (sym_ready_o=0) and is dialed after the flash completes.
- R8: Symbol code 4'hA waits 3600 ms with the line made and mute_o high, then strobes done_o.
- R9: With mode_i=2'b00 (tone), or after symbol code 4'hB, digits cause no line breaks and strobe done_o in the cycle after acceptance. The switch from 4'hB lasts until the next on-hook.
- R10: With lock_en_i=1, the line is held low for 300 ms after off-hook, and sym_ready_o is 0 during that time.
- R11: Going on-hook aborts any sequence: in the next cycle dp_o=1 and mute_o=0, and no done_o follows.
- R12: Symbol codes 4'hC to 4'hF are consumed with done_o in the next cycle and no line activity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| off_hook_i | input | 1 | 1 = handset off-hook |
| lock_en_i | input | 1 | Enables the off-hook line-break delay |
| mode_i | input | 2 | 00 tone, 01 pulse 40:60, 1x pulse 33:67 |
| rate20_i | input | 1 | 0 = 10 pps, 1 = 20 pps |
| sym_valid_i | input | 1 | Symbol offered |
| sym_i | input | 4 | Symbol code: 0..9 digits, A pause, B pulse-to-tone, C..F other |
| sym_ready_o | output | 1 | Symbol accepted on this edge when valid |
| flash_req_i | input | 1 | Flash request, sampled when idle |
| flash_sel_i | input | 2 | Flash length select |
| dp_o | output | 1 | Dial-pulse line, 0 = loop broken |
| mute_o | output | 1 | Timed sequence active |
| done_o | output | 1 | One-cycle completion strobe |

## Verification
A flash request and a symbol offer can both be present in the same idle cycle. The bench provokes this by raising both at one falling edge. It then checks that the line break that follows has the flash length, and that sym_ready_o stays low while the flash runs. It also checks that the held digit then dials with its correct pulse count and timing. Abort by on-hook can also coincide with any running train. It is driven partway through a digit and judged by the line, mute flag and done strobe in the following cycles.

// File: rtl/lpd_pkg.sv
package lpd_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_LOCK, S_BRK, S_MAK, S_GAP, S_FBRK, S_FREC, S_PAUSE
  } lpd_state_e;

  localparam logic [3:0] SYM_PAUSE = 4'hA;
  localparam logic [3:0] SYM_P2T   = 4'hB;

  function automatic logic [3:0] pulses_of(logic [3:0] code);
    return (code == 4'd0) ? 4'd10 : code;
  endfunction
endpackage

// File: rtl/lpd_tick.sv
module lpd_tick #(
  parameter int TICK_CYCLES = 1000
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  generate
    if (TICK_CYCLES <= 1) begin : g_pass
      assign tick_o = 1'b1;
    end else begin : g_div
      localparam int W = $clog2(TICK_CYCLES);
      logic [W-1:0] cnt_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cnt_q <= '0;
        else if (cnt_q == W'(TICK_CYCLES - 1)) cnt_q <= '0;
        else cnt_q <= cnt_q + 1'b1;
      end
      assign tick_o = (cnt_q == W'(TICK_CYCLES - 1));
    end
  endgenerate
endmodule

// File: rtl/lpd_timing.sv
module lpd_timing #(
  parameter int MS_W     = 12,
  parameter int BRK10_40 = 60,
  parameter int MK10_40  = 40,
  parameter int BRK10_33 = 67,
  parameter int MK10_33  = 33,
  parameter int BRK20_40 = 30,
  parameter int MK20_40  = 20,
  parameter int BRK20_33 = 33,
  parameter int MK20_33  = 17,
  parameter int FL0_MS   = 600,
  parameter int FL1_MS   = 300,
  parameter int FL2_MS   = 73,
  parameter int FL3_MS   = 100
) (
  input  logic            rate20_i,
  input  logic            ratio33_i,
  input  logic [1:0]      flash_sel_i,
  output logic [MS_W-1:0] brk_ms_o,
  output logic [MS_W-1:0] mk_ms_o,
  output logic [MS_W-1:0] flash_ms_o
);
  always_comb begin
    unique case ({rate20_i, ratio33_i})
      2'b00: begin brk_ms_o = MS_W'(BRK10_40); mk_ms_o = MS_W'(MK10_40); end
      2'b01: begin brk_ms_o = MS_W'(BRK10_33); mk_ms_o = MS_W'(MK10_33); end
      2'b10: begin brk_ms_o = MS_W'(BRK20_40); mk_ms_o = MS_W'(MK20_40); end
      default: begin brk_ms_o = MS_W'(BRK20_33); mk_ms_o = MS_W'(MK20_33); end
    endcase
    unique case (flash_sel_i)
      2'd0: flash_ms_o = MS_W'(FL0_MS);
      2'd1: flash_ms_o = MS_W'(FL1_MS);
      2'd2: flash_ms_o = MS_W'(FL2_MS);
      default: flash_ms_o = MS_W'(FL3_MS);
    endcase
  end
endmodule

// File: rtl/lpd_seq.sv
module lpd_seq
  import lpd_pkg::*;
#(
  parameter int MS_W     = 12,
  parameter int IDG_MS   = 800,
  parameter int PAUSE_MS = 3600,
  parameter int FREC_MS  = 1000,
  parameter int LOCK_MS  = 300
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            tick_i,
  input  logic            off_hook_i,
  input  logic            lock_en_i,
  input  logic            tone_mode_i,
  input  logic            sym_valid_i,
  input  logic [3:0]      sym_i,
  output logic            sym_ready_o,
  input  logic            flash_req_i,
  input  logic [MS_W-1:0] brk_ms_i,
  input  logic [MS_W-1:0] mk_ms_i,
  input  logic [MS_W-1:0] flash_ms_i,
  output logic            dp_o,
  output logic            mute_o,
  output logic            done_o
);
  lpd_state_e      state_q;
  logic [MS_W-1:0] cnt_q;
  logic [3:0]      pls_q;
  logic            pt_q, hook_q, done_q;
  logic            tone_eff, seg_end;

  assign tone_eff = tone_mode_i | pt_q;
  assign seg_end  = tick_i && (cnt_q == MS_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      cnt_q   <= '0;
      pls_q   <= '0;
      pt_q    <= 1'b0;
      hook_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      hook_q <= off_hook_i;
      done_q <= 1'b0;
      if (!off_hook_i) begin
        state_q <= S_IDLE;
        cnt_q   <= '0;
        pls_q   <= '0;
        pt_q    <= 1'b0;
      end else if (state_q == S_IDLE) begin
        if (!hook_q) begin
          if (lock_en_i) begin
            state_q <= S_LOCK;
            cnt_q   <= MS_W'(LOCK_MS);
          end
        end else if (flash_req_i) begin
          state_q <= S_FBRK;
          cnt_q   <= flash_ms_i;
        end else if (sym_valid_i) begin
          if (sym_i == SYM_PAUSE) begin
            state_q <= S_PAUSE;
            cnt_q   <= MS_W'(PAUSE_MS);
          end else if (sym_i == SYM_P2T) begin
            pt_q   <= 1'b1;
            done_q <= 1'b1;
          end else if (sym_i <= 4'd9 && !tone_eff) begin
            state_q <= S_BRK;
            cnt_q   <= brk_ms_i;
            pls_q   <= pulses_of(sym_i);
          end else begin
            done_q <= 1'b1;
          end
        end
      end else if (tick_i) begin
        if (!seg_end) begin
          cnt_q <= cnt_q - 1'b1;
        end else begin
          unique case (state_q)
            S_BRK: begin
              state_q <= S_MAK;
              cnt_q   <= mk_ms_i;
            end
            S_MAK: begin
              if (pls_q == 4'd1) begin
                state_q <= S_GAP;
                cnt_q   <= MS_W'(IDG_MS);
              end else begin
                state_q <= S_BRK;
                cnt_q   <= brk_ms_i;
              end
              pls_q <= pls_q - 1'b1;
            end
            S_FBRK: begin
              state_q <= S_FREC;
              cnt_q   <= MS_W'(FREC_MS);
            end
            S_LOCK: state_q <= S_IDLE;
            default: begin
              state_q <= S_IDLE;
              done_q  <= 1'b1;
            end
          endcase
        end
      end
    end
  end

  assign dp_o        = !(state_q inside {S_BRK, S_FBRK, S_LOCK});
  assign mute_o      = (state_q != S_IDLE);
  assign done_o      = done_q;
  assign sym_ready_o = (state_q == S_IDLE) && off_hook_i && hook_q && !flash_req_i;

  a_r11_onhook_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !off_hook_i |=> dp_o && !mute_o && !done_o);
  a_r10_lock_break: assert property (@(posedge clk_i) disable iff (!rst_ni)
    off_hook_i && !hook_q && lock_en_i |=> !dp_o);
  a_r7_flash_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_IDLE) && hook_q && off_hook_i && flash_req_i && sym_valid_i
    |=> !dp_o && !done_o);
  a_r1_break_muted: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dp_o |-> mute_o);
  a_r1_ready_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sym_ready_o |-> !mute_o);
  a_r2_train_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_BRK) |-> (pls_q != 4'd0) && (pls_q <= 4'd10));
endmodule

// File: rtl/loop_pulse_dialer.sv
module loop_pulse_dialer #(
  parameter int TICK_CYCLES = 1000,
  parameter int MS_W        = 12,
  parameter int IDG_MS      = 800,
  parameter int PAUSE_MS    = 3600,
  parameter int FREC_MS     = 1000,
  parameter int LOCK_MS     = 300
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       off_hook_i,
  input  logic       lock_en_i,
  input  logic [1:0] mode_i,
  input  logic       rate20_i,
  input  logic       sym_valid_i,
  input  logic [3:0] sym_i,
  output logic       sym_ready_o,
  input  logic       flash_req_i,
  input  logic [1:0] flash_sel_i,
  output logic       dp_o,
  output logic       mute_o,
  output logic       done_o
);
  logic            tick;
  logic [MS_W-1:0] brk_ms, mk_ms, flash_ms;

  lpd_tick #(.TICK_CYCLES(TICK_CYCLES)) u_tick (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_o(tick)
  );

  lpd_timing #(.MS_W(MS_W)) u_timing (
    .rate20_i(rate20_i), .ratio33_i(mode_i[1]), .flash_sel_i(flash_sel_i),
    .brk_ms_o(brk_ms), .mk_ms_o(mk_ms), .flash_ms_o(flash_ms)
  );

  lpd_seq #(
    .MS_W(MS_W), .IDG_MS(IDG_MS), .PAUSE_MS(PAUSE_MS),
    .FREC_MS(FREC_MS), .LOCK_MS(LOCK_MS)
  ) u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick),
    .off_hook_i(off_hook_i), .lock_en_i(lock_en_i),
    .tone_mode_i(mode_i == 2'b00),
    .sym_valid_i(sym_valid_i), .sym_i(sym_i), .sym_ready_o(sym_ready_o),
    .flash_req_i(flash_req_i),
    .brk_ms_i(brk_ms), .mk_ms_i(mk_ms), .flash_ms_i(flash_ms),
    .dp_o(dp_o), .mute_o(mute_o), .done_o(done_o)
  );
endmodule

// File: tb/loop_pulse_dialer_tb_top.sv
module loop_pulse_dialer_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic off_hook = 1'b0, lock_en = 1'b0, rate20 = 1'b0;
  logic [1:0] mode = 2'b01, fsel = 2'd0;
  logic sym_valid = 1'b0, flash_req = 1'b0;
  logic [3:0] sym = 4'd0;
  logic ready, dp, mute, done;
  int n_chk = 0, n_fail = 0;
  int m_np, m_bmin, m_bmax, m_mmin, m_mmax, m_tot;
  bit m_mute1, m_rdy1;

  always #10 clk = ~clk;

  loop_pulse_dialer #(.TICK_CYCLES(1)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .off_hook_i(off_hook), .lock_en_i(lock_en),
    .mode_i(mode), .rate20_i(rate20), .sym_valid_i(sym_valid), .sym_i(sym),
    .sym_ready_o(ready), .flash_req_i(flash_req), .flash_sel_i(fsel),
    .dp_o(dp), .mute_o(mute), .done_o(done)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_brk(input bit r20, input bit r33);
    return r20 ? (r33 ? 33 : 30) : (r33 ? 67 : 60);
  endfunction
  function automatic int exp_mk(input bit r20, input bit r33);
    return r20 ? (r33 ? 17 : 20) : (r33 ? 33 : 40);
  endfunction
  function automatic int exp_fl(input int s);
    return (s == 0) ? 600 : (s == 1) ? 300 : (s == 2) ? 73 : 100;
  endfunction

  task automatic measure(input int limit, input bit keep_sym);
    bit prev = 1'b1;
    int run = 0;
    m_np = 0; m_bmin = 99999; m_bmax = 0; m_mmin = 99999; m_mmax = 0; m_tot = -1;
    for (int k = 1; k <= limit; k++) begin
      @(negedge clk);
      if (k == 1) begin
        if (!keep_sym) sym_valid = 1'b0;
        flash_req = 1'b0;
        m_mute1 = mute; m_rdy1 = ready;
      end
      if (dp != prev) begin
        if (!prev) begin
          if (run < m_bmin) m_bmin = run;
          if (run > m_bmax) m_bmax = run;
        end else if (m_np > 0) begin
          if (run < m_mmin) m_mmin = run;
          if (run > m_mmax) m_mmax = run;
        end
        run = 1;
        if (!dp) m_np++;
      end else run++;
      prev = dp;
      if (done) begin m_tot = k; break; end
    end
  endtask

  task automatic dial(input logic [3:0] code);
    @(negedge clk);
    sym = code; sym_valid = 1'b1;
    measure(6000, 1'b0);
  endtask

  task automatic check_digit(input logic [3:0] code, input string req);
    int n = (code == 0) ? 10 : int'(code);
    int b = exp_brk(rate20, mode[1]);
    int m = exp_mk(rate20, mode[1]);
    chk(m_np == n, {req, " pulse count"}, m_np, n);
    chk(m_bmin == b && m_bmax == b, {req, " break width"}, m_bmax, b);
    if (n > 1) chk(m_mmin == m && m_mmax == m, {req, " make width"}, m_mmax, m);
    chk(m_tot == n * (b + m) + 800 + 1, {req, " R5 done time"}, m_tot, n * (b + m) + 801);
  endtask

  task automatic hook_cycle();
    @(negedge clk); off_hook = 1'b0;
    repeat (3) @(negedge clk);
    off_hook = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #(200000 * 20);
    n_fail++; n_chk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int lows;
    void'($urandom(32'h5eed_0042));
    // R1 reset state
    repeat (3) @(negedge clk);
    chk(dp == 1 && !mute && !done && !ready, "R1 reset", {dp, mute, done, ready}, 4'b1000);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!ready && dp, "R1 on-hook idle", ready, 0);
    off_hook = 1'b1;
    repeat (3) @(negedge clk);
    chk(ready == 1, "R1 ready after off-hook", ready, 1);

    // R2 R3 R5 directed
    mode = 2'b01; rate20 = 1'b0;
    dial(4'd7); check_digit(4'd7, "R2 R3 digit7 40:60");
    dial(4'd0); check_digit(4'd0, "R2 digit0 ten pulses");
    mode = 2'b10;
    dial(4'd4); check_digit(4'd4, "R3 digit4 33:67");
    dial(4'd1); check_digit(4'd1, "R2 digit1 single");
    // R4
    rate20 = 1'b1; mode = 2'b01;
    dial(4'd2); check_digit(4'd2, "R4 20pps 40:60");
    mode = 2'b11;
    dial(4'd3); check_digit(4'd3, "R4 20pps 33:67");

    // random digits over pulse modes and rates
    for (int i = 0; i < 25; i++) begin
      logic [3:0] c = 4'($urandom % 10);
      mode = 2'($urandom % 3 + 1);
      rate20 = 1'($urandom % 2);
      dial(c); check_digit(c, "R2 R3 R4 random");
    end

    // R6 flash in pulse mode, each select
    mode = 2'b01; rate20 = 1'b0;
    for (int s = 0; s < 4; s++) begin
      @(negedge clk); fsel = 2'(s); flash_req = 1'b1;
      measure(3000, 1'b0);
      chk(m_np == 1 && m_bmax == exp_fl(s) && m_bmin == exp_fl(s), "R6 flash break", m_bmax, exp_fl(s));
      chk(m_tot == exp_fl(s) + 1001, "R6 flash recovery", m_tot, exp_fl(s) + 1001);
    end
    mode = 2'b00;
    @(negedge clk); fsel = 2'd2; flash_req = 1'b1;
    measure(3000, 1'b0);
    chk(m_np == 1 && m_bmax == 73 && m_tot == 1074, "R6 flash tone mode", m_tot, 1074);

    // R7 flash and symbol same cycle
    mode = 2'b01;
    @(negedge clk); fsel = 2'd3; flash_req = 1'b1; sym = 4'd2; sym_valid = 1'b1;
    measure(3000, 1'b1);
    chk(m_rdy1 == 0, "R7 symbol held", m_rdy1, 0);
    chk(m_np == 1 && m_bmax == 100 && m_tot == 1101, "R7 flash first", m_bmax, 100);
    measure(6000, 1'b0);
    check_digit(4'd2, "R7 held digit");

    // R8 pause
    dial(4'hA);
    chk(m_np == 0 && m_mute1 && m_tot == 3601, "R8 pause", m_tot, 3601);

    // R12 other codes
    dial(4'hC);
    chk(m_np == 0 && m_tot == 1, "R12 code C", m_tot, 1);
    dial(4'hF);
    chk(m_np == 0 && m_tot == 1, "R12 code F", m_tot, 1);

    // R9 tone mode and pulse-to-tone
    mode = 2'b00;
    dial(4'd5);
    chk(m_np == 0 && m_tot == 1, "R9 tone digit", m_np, 0);
    mode = 2'b01;
    dial(4'hB);
    chk(m_np == 0 && m_tot == 1, "R9 p2t symbol", m_tot, 1);
    dial(4'd3);
    chk(m_np == 0 && m_tot == 1, "R9 after p2t", m_np, 0);
    hook_cycle();
    dial(4'd3); check_digit(4'd3, "R9 p2t cleared by hook");

    // R11 abort
    @(negedge clk); sym = 4'd5; sym_valid = 1'b1;
    @(negedge clk); sym_valid = 1'b0;
    repeat (30) @(negedge clk);
    chk(!dp && mute, "R11 busy before abort", dp, 0);
    off_hook = 1'b0;
    @(negedge clk);
    chk(dp && !mute && !ready, "R11 abort idle", {dp, mute, ready}, 3'b100);
    lows = 0;
    repeat (50) begin @(negedge clk); if (done || !dp) lows++; end
    chk(lows == 0, "R11 no done after abort", lows, 0);

    // R10 lock delay
    lock_en = 1'b1; off_hook = 1'b1;
    lows = 0;
    for (int k = 1; k <= 400; k++) begin
      @(negedge clk);
      if (k == 1) chk(!ready && mute, "R10 ready low in lock", ready, 0);
      if (!dp) lows++; else break;
    end
    chk(lows == 300, "R10 lock break length", lows, 300);
    chk(ready == 1, "R10 ready after lock", ready, 1);
    lock_en = 1'b0;
    dial(4'd1); check_digit(4'd1, "R10 dial after lock");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule